// File: doc/BRIEF.md
# Programmable Panel Timing Generator

This block produces the raster timing for a flat-panel display from a free-running display clock. Two counters walk the raster: a pixel counter that runs across each line and a line counter that steps once per line. From their values the block forms a horizontal sync pulse, a vertical sync pulse, a horizontal data-enable window and a vertical data-enable window. Each pulse and window has its own start, width or end, and its own polarity, all taken from configuration inputs.

The vertical sync pin can instead carry a composite sync. This is the horizontal and vertical sync pulses combined by exclusive-or. The vertical enable pin can instead carry a composite enable. This is the overlap of the two enable windows. The configuration is captured into shadow registers only at the start of a frame, so software may change it at any time without producing a torn frame.

Every output comes from a flop, and the pixel and line counts are delivered in the same registered stage as the timing signals. A downstream pixel path can therefore use the counts and the enables as one aligned set.

Top module: `panel_timing_gen`

## Requirements
- R1: While reset is asserted, all four timing outputs and both count outputs are 0.
- R2: At the first clock edge after reset is released, the block captures the configuration. The timing outputs take their inactive levels and both counts read 0. From the second edge on, each edge presents the next raster position, starting at pixel 0 of line 0. Every output shows the timing of the position on the count outputs.
- R3: The pixel count runs 0, 1, ..., h_total-1 and then returns to 0. The line count advances when the pixel count returns to 0, and it returns to 0 after line v_total-1.
- R4: Raw horizontal sync is active on pixels p with h_sync_start <= p < h_sync_start + h_sync_width. A width of 0 gives no pulse. A pulse that would run past the line end is cut off there.
- R5: Raw vertical sync is active on lines l with v_sync_start <= l < v_sync_start + v_sync_width, for every pixel of those lines.
- R6: Raw horizontal enable is active on pixels p with h_de_start <= p < h_de_end. Raw vertical enable is active on lines l with v_de_start <= l < v_de_end.
- R7: Each output has its own polarity bit: hsync_low, vsync_low, hde_low and vde_low. A bit of 0 drives the output high when active. A bit of 1 drives it low when active. The inactive level of an output equals its polarity bit.
- R8: With csync_en = 1, vsync_o carries raw horizontal sync XOR raw vertical sync, with the vsync_low polarity applied after the XOR.
- R9: With cde_en = 1, vde_o carries raw horizontal enable AND raw vertical enable, with the vde_low polarity applied after the AND.
- R10: A configuration change takes effect only from pixel 0 of line 0 of the next frame. Until then the running frame keeps its old totals, positions, polarities and modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| h_total | input | 12 | Clocks per line |
| h_sync_start | input | 12 | First pixel of horizontal sync |
| h_sync_width | input | 12 | Horizontal sync length in clocks |
| h_de_start | input | 12 | First pixel of the horizontal enable window |
| h_de_end | input | 12 | Pixel just past the horizontal enable window |
| v_total | input | 12 | Lines per frame |
| v_sync_start | input | 12 | First line of vertical sync |
| v_sync_width | input | 12 | Vertical sync length in lines |
| v_de_start | input | 12 | First line of the vertical enable window |
| v_de_end | input | 12 | Line just past the vertical enable window |
| hsync_low | input | 1 | Horizontal sync active low when 1 |
| vsync_low | input | 1 | Vertical sync pin active low when 1 |
| hde_low | input | 1 | Horizontal enable active low when 1 |
| vde_low | input | 1 | Vertical enable pin active low when 1 |
| csync_en | input | 1 | Vertical sync pin carries composite sync |
| cde_en | input | 1 | Vertical enable pin carries composite enable |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical or composite sync |
| hde_o | output | 1 | Horizontal data enable |
| vde_o | output | 1 | Vertical or composite data enable |
| pix_cnt_o | output | 12 | Pixel position of the current outputs |
| line_cnt_o | output | 12 | Line position of the current outputs |

## Verification
The timing is compared at every clock against positions computed arithmetically on a small 10 by 6 raster. The first setup uses all-high polarities and separate signals, which isolates the window arithmetic from the inversion stage. A second setup inverts all four outputs, so a swapped or missing polarity bit shows up. A third setup is written partway through a frame and also changes the totals; it shows whether the new values land exactly at the frame boundary rather than at once. A closing sweep runs horizontal sync starts 0 to 9 against widths 0 to 3. It varies the vertical settings, the composite modes and the polarity bits with it, and so covers zero-width pulses, pulses cut off at the line end, and the XOR and AND merges on the vertical pins.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    // Default width of the raster counters and position fields.
    localparam int unsigned CNT_W_DEF = 12;

    // One bit per output: 1 means the output is driven low while active.
    typedef struct packed {
        logic hs_low;
        logic vs_low;
        logic hde_low;
        logic vde_low;
    } pol_t;

endpackage

// File: rtl/ptg_axis_cnt.sv
module ptg_axis_cnt #(
    parameter int unsigned CNT_W = ptg_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CNT_W-1:0] total_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign last_o = (cnt_q == (total_i - ONE));
    assign cnt_o  = cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (en_i) begin
            cnt_d = last_o ? '0 : (cnt_q + ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == '0)));

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(cnt_q));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (total_i != '0)) |-> (cnt_q <= total_i - ONE));

endmodule

// File: rtl/ptg_axis_win.sv
module ptg_axis_win #(
    parameter int unsigned CNT_W = ptg_pkg::CNT_W_DEF
) (
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] sync_start_i,
    input  logic [CNT_W-1:0] sync_width_i,
    input  logic [CNT_W-1:0] de_start_i,
    input  logic [CNT_W-1:0] de_end_i,
    output logic             sync_o,
    output logic             de_o
);

    // Offset into the pulse, one bit wider so the subtraction cannot alias.
    logic [CNT_W:0] offset;

    always_comb begin
        offset = {1'b0, cnt_i} - {1'b0, sync_start_i};
        sync_o = (cnt_i >= sync_start_i) && (offset < {1'b0, sync_width_i});
        de_o   = (cnt_i >= de_start_i) && (cnt_i < de_end_i);
    end

endmodule

// File: rtl/ptg_out_stage.sv
module ptg_out_stage #(
    parameter int unsigned CNT_W = ptg_pkg::CNT_W_DEF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_i,
    input  ptg_pkg::pol_t      pol_run_i,
    input  ptg_pkg::pol_t      pol_idle_i,
    input  logic               csync_i,
    input  logic               cde_i,
    input  logic [CNT_W-1:0]   h_cnt_i,
    input  logic [CNT_W-1:0]   v_cnt_i,
    input  logic               hs_i,
    input  logic               vs_i,
    input  logic               hde_i,
    input  logic               vde_i,
    output logic               hsync_o,
    output logic               vsync_o,
    output logic               hde_o,
    output logic               vde_o,
    output logic [CNT_W-1:0]   pix_cnt_o,
    output logic [CNT_W-1:0]   line_cnt_o
);

    typedef struct packed {
        logic             hs;
        logic             vs;
        logic             hde;
        logic             vde;
        logic [CNT_W-1:0] pix;
        logic [CNT_W-1:0] line;
    } out_t;

    out_t o_d, o_q;
    logic vs_mix;
    logic vde_mix;

    always_comb begin
        o_d     = '0;
        vs_mix  = csync_i ? (hs_i ^ vs_i) : vs_i;
        vde_mix = cde_i ? (hde_i & vde_i) : vde_i;
        if (run_i) begin
            // Polarity is the last stage before the flops.
            o_d.hs   = hs_i    ^ pol_run_i.hs_low;
            o_d.vs   = vs_mix  ^ pol_run_i.vs_low;
            o_d.hde  = hde_i   ^ pol_run_i.hde_low;
            o_d.vde  = vde_mix ^ pol_run_i.vde_low;
            o_d.pix  = h_cnt_i;
            o_d.line = v_cnt_i;
        end else begin
            o_d.hs   = pol_idle_i.hs_low;
            o_d.vs   = pol_idle_i.vs_low;
            o_d.hde  = pol_idle_i.hde_low;
            o_d.vde  = pol_idle_i.vde_low;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign hsync_o    = o_q.hs;
    assign vsync_o    = o_q.vs;
    assign hde_o      = o_q.hde;
    assign vde_o      = o_q.vde;
    assign pix_cnt_o  = o_q.pix;
    assign line_cnt_o = o_q.line;

    // R2
    idle_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> ((pix_cnt_o == '0) && (line_cnt_o == '0)));

    // R7
    hs_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !hs_i) |=> (hsync_o == $past(pol_run_i.hs_low)));

    // R8
    csync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && csync_i && hs_i && !vs_i) |=> (vsync_o == !$past(pol_run_i.vs_low)));

    // R9
    cde_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && cde_i && !hde_i) |=> (vde_o == $past(pol_run_i.vde_low)));

endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen #(
    parameter int unsigned CNT_W = ptg_pkg::CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] h_total,
    input  logic [CNT_W-1:0] h_sync_start,
    input  logic [CNT_W-1:0] h_sync_width,
    input  logic [CNT_W-1:0] h_de_start,
    input  logic [CNT_W-1:0] h_de_end,
    input  logic [CNT_W-1:0] v_total,
    input  logic [CNT_W-1:0] v_sync_start,
    input  logic [CNT_W-1:0] v_sync_width,
    input  logic [CNT_W-1:0] v_de_start,
    input  logic [CNT_W-1:0] v_de_end,
    input  logic             hsync_low,
    input  logic             vsync_low,
    input  logic             hde_low,
    input  logic             vde_low,
    input  logic             csync_en,
    input  logic             cde_en,
    output logic             hsync_o,
    output logic             vsync_o,
    output logic             hde_o,
    output logic             vde_o,
    output logic [CNT_W-1:0] pix_cnt_o,
    output logic [CNT_W-1:0] line_cnt_o
);

    // Axis 0 is horizontal (pixels), axis 1 is vertical (lines).
    localparam int unsigned NAX = 2;

    typedef struct packed {
        logic                      primed;
        logic [NAX-1:0][CNT_W-1:0] total;
        logic [NAX-1:0][CNT_W-1:0] ss;
        logic [NAX-1:0][CNT_W-1:0] sw;
        logic [NAX-1:0][CNT_W-1:0] ds;
        logic [NAX-1:0][CNT_W-1:0] de;
        ptg_pkg::pol_t             pol;
        logic                      csync;
        logic                      cde;
    } shadow_t;

    shadow_t st_d, st_q;

    logic [NAX-1:0][CNT_W-1:0] in_total, in_ss, in_sw, in_ds, in_de;
    ptg_pkg::pol_t             in_pol;

    logic [NAX-1:0][CNT_W-1:0] ax_cnt;
    logic [NAX-1:0]            ax_en, ax_last, ax_sync, ax_de;
    logic                      frame_end;
    logic                      load;

    assign in_total = {v_total,      h_total};
    assign in_ss    = {v_sync_start, h_sync_start};
    assign in_sw    = {v_sync_width, h_sync_width};
    assign in_ds    = {v_de_start,   h_de_start};
    assign in_de    = {v_de_end,     h_de_end};

    assign in_pol.hs_low  = hsync_low;
    assign in_pol.vs_low  = vsync_low;
    assign in_pol.hde_low = hde_low;
    assign in_pol.vde_low = vde_low;

    assign frame_end = ax_last[0] & ax_last[1];
    assign load      = !st_q.primed || frame_end;

    // Shadow configuration: captured once after reset and at each frame start.
    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.primed = 1'b1;
            st_d.total  = in_total;
            st_d.ss     = in_ss;
            st_d.sw     = in_sw;
            st_d.ds     = in_ds;
            st_d.de     = in_de;
            st_d.pol    = in_pol;
            st_d.csync  = csync_en;
            st_d.cde    = cde_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ax_en[0] = st_q.primed;
    assign ax_en[1] = st_q.primed & ax_last[0];

    for (genvar gi = 0; gi < NAX; gi++) begin : g_axis
        ptg_axis_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (ax_en[gi]),
            .total_i (st_q.total[gi]),
            .cnt_o   (ax_cnt[gi]),
            .last_o  (ax_last[gi])
        );

        ptg_axis_win #(.CNT_W(CNT_W)) u_win (
            .cnt_i        (ax_cnt[gi]),
            .sync_start_i (st_q.ss[gi]),
            .sync_width_i (st_q.sw[gi]),
            .de_start_i   (st_q.ds[gi]),
            .de_end_i     (st_q.de[gi]),
            .sync_o       (ax_sync[gi]),
            .de_o         (ax_de[gi])
        );
    end

    ptg_out_stage #(.CNT_W(CNT_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (st_q.primed),
        .pol_run_i  (st_q.pol),
        .pol_idle_i (in_pol),
        .csync_i    (st_q.csync),
        .cde_i      (st_q.cde),
        .h_cnt_i    (ax_cnt[0]),
        .v_cnt_i    (ax_cnt[1]),
        .hs_i       (ax_sync[0]),
        .vs_i       (ax_sync[1]),
        .hde_i      (ax_de[0]),
        .vde_i      (ax_de[1]),
        .hsync_o    (hsync_o),
        .vsync_o    (vsync_o),
        .hde_o      (hde_o),
        .vde_o      (vde_o),
        .pix_cnt_o  (pix_cnt_o),
        .line_cnt_o (line_cnt_o)
    );

    // R10
    shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && !frame_end) |=> $stable(st_q));

    // R10
    frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && frame_end) |=> ((ax_cnt[0] == '0) && (ax_cnt[1] == '0)));

    // R3
    line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.primed && !ax_last[0]) |=> $stable(ax_cnt[1]));

endmodule

// File: tb/sim_panel_timing_gen.sv
`timescale 1ns/1ps
module sim_panel_timing_gen;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    typedef struct {
        int ht, hss, hsw, hds, hde;
        int vt, vss, vsw, vds, vde;
        bit hsl, vsl, hdl, vdl, cs, cd;
    } bcfg_t;

    bcfg_t cur, app, disp;
    bit    m_primed = 1'b0;
    bit    d_valid  = 1'b0;
    int    m_h = 0, m_v = 0, dh = 0, dv = 0;
    int    chk_n = 0, err_n = 0;
    bit    done = 1'b0;
    string phase = "R1";

    logic        hsync_o, vsync_o, hde_o, vde_o;
    logic [11:0] pix_cnt_o, line_cnt_o;

    panel_timing_gen u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .h_total      (cur.ht[11:0]),
        .h_sync_start (cur.hss[11:0]),
        .h_sync_width (cur.hsw[11:0]),
        .h_de_start   (cur.hds[11:0]),
        .h_de_end     (cur.hde[11:0]),
        .v_total      (cur.vt[11:0]),
        .v_sync_start (cur.vss[11:0]),
        .v_sync_width (cur.vsw[11:0]),
        .v_de_start   (cur.vds[11:0]),
        .v_de_end     (cur.vde[11:0]),
        .hsync_low    (cur.hsl),
        .vsync_low    (cur.vsl),
        .hde_low      (cur.hdl),
        .vde_low      (cur.vdl),
        .csync_en     (cur.cs),
        .cde_en       (cur.cd),
        .hsync_o      (hsync_o),
        .vsync_o      (vsync_o),
        .hde_o        (hde_o),
        .vde_o        (vde_o),
        .pix_cnt_o    (pix_cnt_o),
        .line_cnt_o   (line_cnt_o)
    );

    function automatic bcfg_t mk(int ht, int hss, int hsw, int hds, int hde,
                                 int vt, int vss, int vsw, int vds, int vde,
                                 bit [5:0] m);
        bcfg_t c;
        c.ht = ht;  c.hss = hss; c.hsw = hsw; c.hds = hds; c.hde = hde;
        c.vt = vt;  c.vss = vss; c.vsw = vsw; c.vds = vds; c.vde = vde;
        c.hsl = m[5]; c.vsl = m[4]; c.hdl = m[3]; c.vdl = m[2];
        c.cs  = m[1]; c.cd  = m[0];
        return c;
    endfunction

    // Reference raster position model, advanced on the same edges as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_primed = 1'b0;
            d_valid  = 1'b0;
            m_h = 0; m_v = 0; dh = 0; dv = 0;
            disp = mk(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6'b0);
        end else if (!m_primed) begin
            app      = cur;
            disp     = cur;
            d_valid  = 1'b0;
            m_primed = 1'b1;
        end else begin
            d_valid = 1'b1;
            dh   = m_h;
            dv   = m_v;
            disp = app;
            if (m_h == app.ht - 1) begin
                m_h = 0;
                if (m_v == app.vt - 1) begin
                    m_v = 0;
                    app = cur;
                end else begin
                    m_v = m_v + 1;
                end
            end else begin
                m_h = m_h + 1;
            end
        end
    end

    task automatic chk(string tag, int got, int exp);
        chk_n++;
        if (got != exp) begin
            err_n++;
            $display("FAIL %s (%s) pix=%0d line=%0d got %0d expected %0d",
                     tag, phase, dh, dv, got, exp);
        end
    endtask

    task automatic check_all();
        bit hs_r, vs_r, hd_r, vd_r;
        int ehs, evs, ehd, evd, epix, eline;
        if (!d_valid) begin
            ehs = disp.hsl; evs = disp.vsl; ehd = disp.hdl; evd = disp.vdl;
            epix = 0; eline = 0;
        end else begin
            hs_r = (dh >= disp.hss) && (dh < disp.hss + disp.hsw);
            vs_r = (dv >= disp.vss) && (dv < disp.vss + disp.vsw);
            hd_r = (dh >= disp.hds) && (dh < disp.hde);
            vd_r = (dv >= disp.vds) && (dv < disp.vde);
            ehs  = int'(hs_r ^ disp.hsl);
            evs  = int'((disp.cs ? (hs_r ^ vs_r) : vs_r) ^ disp.vsl);
            ehd  = int'(hd_r ^ disp.hdl);
            evd  = int'((disp.cd ? (hd_r & vd_r) : vd_r) ^ disp.vdl);
            epix = dh; eline = dv;
        end
        chk("R3 pixel", int'(pix_cnt_o), epix);
        chk("R3 line",  int'(line_cnt_o), eline);
        chk(disp.hsl ? "R7 hsync" : "R4 hsync", int'(hsync_o), ehs);
        chk(disp.cs  ? "R8 vsync" : "R5 vsync", int'(vsync_o), evs);
        chk(disp.hdl ? "R7 hde"   : "R6 hde",   int'(hde_o),   ehd);
        chk(disp.cd  ? "R9 vde"   : "R6 vde",   int'(vde_o),   evd);
    endtask

    task automatic run(int n);
        repeat (n) begin
            @(negedge clk);
            check_all();
        end
    endtask

    initial begin
        cur = mk(10, 2, 3, 1, 8, 6, 1, 2, 1, 5, 6'b000000);
        phase = "R1";
        run(3);
        rst_n = 1'b1;
        phase = "R2";
        run(4);
        phase = "R3";
        run(180);
        // All outputs inverted, windows reaching the line and frame ends.
        cur = mk(10, 7, 3, 0, 10, 6, 4, 2, 0, 6, 6'b111100);
        phase = "R7";
        run(150);
        // Written mid-frame with new totals: must wait for the frame start.
        run(23);
        cur = mk(8, 1, 2, 2, 6, 5, 0, 1, 1, 4, 6'b010011);
        phase = "R10";
        run(130);
        // Sweep of sync start and width with modes and polarities varied.
        for (int s = 0; s < 10; s++) begin
            for (int w = 0; w < 4; w++) begin
                bit [5:0] m;
                m = {s[0], s[1], w[0], w[1], s[2], w[0] ^ s[0]};
                cur = mk(10, s, w, s % 5, (s % 5) + w + 2,
                         6, s % 6, w % 3, s % 3, (s % 3) + (w % 4) + 1, m);
                phase = "R8";
                run(130);
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", err_n, chk_n);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk_n++;
            err_n++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("Result: errors=%0d of %0d checks", err_n, chk_n);
            $finish;
        end
    end

endmodule